// File: doc/BRIEF.md
# Multiplexed Utility Bus Master

This block lets on-chip logic reach the management registers of PHY devices over a slow 8-bit peripheral bus on which address and data take turns on the same wires. A request port hands over one register access at a time: an address, a device select, write data and a direction bit. The block then runs the whole bus sequence. An address phase is marked by an address-latch strobe. A read or write strobe follows, and a chip select frames the whole access. For a read, the byte is returned together with a single-cycle completion pulse. Two side functions sit next to the bus: a PHY reset output, and a synchroniser that turns the PHY interrupt line into a sticky status bit.

Every minimum width and hold time is a cycle count set by a parameter. The defaults suit an 80 MHz core clock (12.5 ns per cycle), with each phase rounded up to whole cycles. The shared lines leave the block as a separate output value, output enable and input value, which the pad cell combines into the bidirectional bus. All strobes and chip selects are active low and come straight from flops.

Top module: `util_bus_master`

## Requirements
- R1: While reset is held and after it is released, all chip selects, the read strobe and the write strobe are high. The latch strobe, the output enable, busy and done are low, and phyReset is high.
- R2: A request is taken only while busy is low. Busy is high from the cycle after acceptance until the cycle in which done pulses, when it is low again. A request presented while busy is ignored and starts no bus cycle.
- R3: Each access starts with the latch strobe high for exactly ALE_CYC cycles, with the address driven on the shared lines. The selected chip select is already low while the latch strobe is high. The address stays driven for ADDR_HOLD_CYC cycles after the latch strobe falls.
- R4: reqSel=0 drives utlCsN[0] and reqSel=1 drives utlCsN[1]. At most one chip select is low at any time. The selected one stays low for ALE_CYC+ADDR_HOLD_CYC+STROBE_CYC+DATA_HOLD_CYC cycles, so it rises only after the read or write strobe has ended.
- R5: In a write (reqWrite=1), the write strobe is low for exactly STROBE_CYC cycles. It goes low only after the latch strobe has fallen. The write byte is driven throughout that time and for DATA_HOLD_CYC cycles after the write strobe rises.
- R6: In a read (reqWrite=0), the read strobe is low for exactly STROBE_CYC cycles and the write strobe stays high. The output enable is low from the end of the address hold until the chip select rises, and for at least one cycle after that.
- R7: Read data is the value on the input lines at the clock edge where the chip select rises. A value present only while the read strobe was low is not returned.
- R8: Done is a single-cycle pulse in the cycle in which the chip select has just returned high, for reads and writes alike. rdData is valid in that cycle.
- R9: phyIrq passes two synchroniser flops and then sets irqStatus, which is visible three clock edges after the input rises. While the synchronised input is high, irqClear has no effect. Once the input is low, irqClear returns irqStatus to zero.
- R10: phyReset is high during reset. Afterwards it follows phyResetCtl, one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, taken when busy is low |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| reqSel | input | SEL_W | Device select, picks the chip select |
| reqAddr | input | BUS_W | Register address |
| reqWdata | input | BUS_W | Write byte |
| busy | output | 1 | A bus cycle is in progress |
| done | output | 1 | Single-cycle completion pulse |
| rdData | output | BUS_W | Byte captured by the last read |
| utlAle | output | 1 | Address latch strobe, active high |
| utlCsN | output | NUM_CS | Chip selects, active low |
| utlRdN | output | 1 | Read strobe, active low |
| utlWrN | output | 1 | Write strobe, active low |
| utlAdOut | output | BUS_W | Value driven on the shared lines |
| utlAdOe | output | 1 | Output enable for the shared lines |
| utlAdIn | input | BUS_W | Value seen on the shared lines |
| phyResetCtl | input | 1 | Requested PHY reset level |
| phyReset | output | 1 | PHY reset, active high |
| phyIrq | input | 1 | Asynchronous PHY interrupt |
| irqClear | input | 1 | Clears the sticky interrupt bit |
| irqStatus | output | 1 | Sticky synchronised interrupt |

## Verification
The bench's peripheral model puts one byte on the input lines while the read strobe is low and a different byte after the strobe rises but before the chip select rises. A design that sampled at the end of the read strobe would return the first byte instead of the second. The bench reads the shared lines in the first cycle after the latch strobe falls and in the first cycle after the write strobe rises. A design without the hold cycles would show the output enable dropped or the wrong byte in those cycles. A second request is injected in the middle of a transfer; a design that took it would produce an extra latch pulse. The interrupt bit is sampled one edge before and at the edge where it should appear, which exposes a wrong synchroniser depth. A clear is pulsed while the input is still high, which exposes clear being given priority over set.

// File: rtl/ubm_pkg.sv
package ubm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AHOLD,
    ST_STROBE,
    ST_RECOV,
    ST_FIN
  } ubm_state_e;

  // Per-cycle control intent handed from the sequencer to the datapath.
  typedef struct packed {
    logic load;       // capture the request fields
    logic ale;        // latch strobe wanted
    logic cs;         // selected chip select wanted
    logic rd;         // read strobe wanted
    logic wr;         // write strobe wanted
    logic driveAddr;  // put the address on the shared lines
    logic driveData;  // put the write byte on the shared lines
    logic done;       // completion pulse
  } ubm_strobe_t;

endpackage

// File: rtl/ubm_ctrl.sv
module ubm_ctrl
  import ubm_pkg::*;
#(
  parameter int ALE_CYC       = 2,
  parameter int ADDR_HOLD_CYC = 1,
  parameter int STROBE_CYC    = 15,
  parameter int DATA_HOLD_CYC = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  output logic        busy,
  output ubm_strobe_t stb
);

  localparam int MAX_A   = (ALE_CYC > ADDR_HOLD_CYC) ? ALE_CYC : ADDR_HOLD_CYC;
  localparam int MAX_B   = (STROBE_CYC > DATA_HOLD_CYC) ? STROBE_CYC : DATA_HOLD_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  ubm_state_e state, stateNext;
  logic [CNT_W-1:0] phaseCnt, phaseCntNext;
  logic writeReg;
  logic accept;

  assign accept = (state == ST_IDLE) && reqValid;
  assign busy   = (state != ST_IDLE);

  always_comb begin
    stateNext    = state;
    phaseCntNext = phaseCnt;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          stateNext    = ST_ADDR;
          phaseCntNext = CNT_W'(ALE_CYC - 1);
        end
      end
      ST_ADDR: begin
        if (phaseCnt == '0) begin
          stateNext    = ST_AHOLD;
          phaseCntNext = CNT_W'(ADDR_HOLD_CYC - 1);
        end else begin
          phaseCntNext = phaseCnt - 1'b1;
        end
      end
      ST_AHOLD: begin
        if (phaseCnt == '0) begin
          stateNext    = ST_STROBE;
          phaseCntNext = CNT_W'(STROBE_CYC - 1);
        end else begin
          phaseCntNext = phaseCnt - 1'b1;
        end
      end
      ST_STROBE: begin
        if (phaseCnt == '0) begin
          stateNext    = ST_RECOV;
          phaseCntNext = CNT_W'(DATA_HOLD_CYC - 1);
        end else begin
          phaseCntNext = phaseCnt - 1'b1;
        end
      end
      ST_RECOV: begin
        if (phaseCnt == '0) begin
          stateNext = ST_FIN;
        end else begin
          phaseCntNext = phaseCnt - 1'b1;
        end
      end
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      writeReg <= 1'b0;
    end else begin
      state    <= stateNext;
      phaseCnt <= phaseCntNext;
      if (accept) writeReg <= reqWrite;
    end
  end

  always_comb begin
    stb      = '0;
    stb.load = accept;
    unique case (state)
      ST_ADDR: begin
        stb.ale       = 1'b1;
        stb.cs        = 1'b1;
        stb.driveAddr = 1'b1;
      end
      ST_AHOLD: begin
        stb.cs        = 1'b1;
        stb.driveAddr = 1'b1;
      end
      ST_STROBE: begin
        stb.cs        = 1'b1;
        stb.wr        = writeReg;
        stb.rd        = !writeReg;
        stb.driveData = writeReg;
      end
      ST_RECOV: begin
        stb.cs        = 1'b1;
        stb.driveData = writeReg;
      end
      ST_FIN:  stb.done = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/ubm_datapath.sv
module ubm_datapath
  import ubm_pkg::*;
#(
  parameter int BUS_W  = 8,
  parameter int NUM_CS = 2,
  parameter int SEL_W  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ubm_strobe_t       stb,
  input  logic              reqWrite,
  input  logic [SEL_W-1:0]  reqSel,
  input  logic [BUS_W-1:0]  reqAddr,
  input  logic [BUS_W-1:0]  reqWdata,
  input  logic [BUS_W-1:0]  utlAdIn,
  output logic              utlAle,
  output logic [NUM_CS-1:0] utlCsN,
  output logic              utlRdN,
  output logic              utlWrN,
  output logic [BUS_W-1:0]  utlAdOut,
  output logic              utlAdOe,
  output logic [BUS_W-1:0]  rdData,
  output logic              done
);

  logic [SEL_W-1:0]  selReg;
  logic [BUS_W-1:0]  addrReg, wdataReg;
  logic              writeReg;
  logic [NUM_CS-1:0] csNNext;
  logic              csActive;
  logic              captureNow;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_csDecode
    assign csNNext[i] = !(stb.cs && (selReg == SEL_W'(i)));
  end

  assign csActive   = (utlCsN != {NUM_CS{1'b1}});
  assign captureNow = !writeReg && csActive && !stb.cs;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg   <= '0;
      addrReg  <= '0;
      wdataReg <= '0;
      writeReg <= 1'b0;
    end else if (stb.load) begin
      selReg   <= reqSel;
      addrReg  <= reqAddr;
      wdataReg <= reqWdata;
      writeReg <= reqWrite;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      utlAle   <= 1'b0;
      utlCsN   <= {NUM_CS{1'b1}};
      utlRdN   <= 1'b1;
      utlWrN   <= 1'b1;
      utlAdOut <= '0;
      utlAdOe  <= 1'b0;
      done     <= 1'b0;
      rdData   <= '0;
    end else begin
      utlAle  <= stb.ale;
      utlCsN  <= csNNext;
      utlRdN  <= !stb.rd;
      utlWrN  <= !stb.wr;
      utlAdOe <= stb.driveAddr || stb.driveData;
      if (stb.driveAddr)      utlAdOut <= addrReg;
      else if (stb.driveData) utlAdOut <= wdataReg;
      else                    utlAdOut <= '0;
      done <= stb.done;
      if (captureNow) rdData <= utlAdIn;
    end
  end

endmodule

// File: rtl/ubm_phy_side.sv
module ubm_phy_side #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic phyResetCtl,
  input  logic phyIrq,
  input  logic irqClear,
  output logic phyReset,
  output logic irqStatus
);

  logic [SYNC_STAGES-1:0] syncChain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '0;
      irqStatus <= 1'b0;
      phyReset  <= 1'b1;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], phyIrq};
      if (syncChain[SYNC_STAGES-1]) irqStatus <= 1'b1;
      else if (irqClear)            irqStatus <= 1'b0;
      phyReset <= phyResetCtl;
    end
  end

endmodule

// File: rtl/util_bus_master.sv
module util_bus_master
  import ubm_pkg::*;
#(
  parameter int BUS_W         = 8,
  parameter int NUM_CS        = 2,
  parameter int ALE_CYC       = 2,
  parameter int ADDR_HOLD_CYC = 1,
  parameter int STROBE_CYC    = 15,
  parameter int DATA_HOLD_CYC = 1,
  localparam int SEL_W        = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [SEL_W-1:0]  reqSel,
  input  logic [BUS_W-1:0]  reqAddr,
  input  logic [BUS_W-1:0]  reqWdata,
  output logic              busy,
  output logic              done,
  output logic [BUS_W-1:0]  rdData,
  output logic              utlAle,
  output logic [NUM_CS-1:0] utlCsN,
  output logic              utlRdN,
  output logic              utlWrN,
  output logic [BUS_W-1:0]  utlAdOut,
  output logic              utlAdOe,
  input  logic [BUS_W-1:0]  utlAdIn,
  input  logic              phyResetCtl,
  output logic              phyReset,
  input  logic              phyIrq,
  input  logic              irqClear,
  output logic              irqStatus
);

  ubm_strobe_t stb;

  ubm_ctrl #(
    .ALE_CYC      (ALE_CYC),
    .ADDR_HOLD_CYC(ADDR_HOLD_CYC),
    .STROBE_CYC   (STROBE_CYC),
    .DATA_HOLD_CYC(DATA_HOLD_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .busy    (busy),
    .stb     (stb)
  );

  ubm_datapath #(
    .BUS_W (BUS_W),
    .NUM_CS(NUM_CS),
    .SEL_W (SEL_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .reqWrite(reqWrite),
    .reqSel  (reqSel),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .utlAdIn (utlAdIn),
    .utlAle  (utlAle),
    .utlCsN  (utlCsN),
    .utlRdN  (utlRdN),
    .utlWrN  (utlWrN),
    .utlAdOut(utlAdOut),
    .utlAdOe (utlAdOe),
    .rdData  (rdData),
    .done    (done)
  );

  ubm_phy_side #(
    .SYNC_STAGES(2)
  ) u_phy (
    .clk        (clk),
    .rstN       (rstN),
    .phyResetCtl(phyResetCtl),
    .phyIrq     (phyIrq),
    .irqClear   (irqClear),
    .phyReset   (phyReset),
    .irqStatus  (irqStatus)
  );

endmodule

// File: rtl/ubm_checker.sv
module ubm_checker #(
  parameter int NUM_CS = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic              utlAle,
  input logic [NUM_CS-1:0] utlCsN,
  input logic              utlRdN,
  input logic              utlWrN,
  input logic              utlAdOe
);

  localparam logic [NUM_CS-1:0] CS_IDLE = {NUM_CS{1'b1}};

  assert_cs_under_ale_R3: assert property (@(posedge clk) disable iff (!rstN)
    utlAle |-> (utlCsN != CS_IDLE) && utlAdOe);

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(utlAle) |-> utlAdOe && (utlCsN != CS_IDLE));

  assert_one_cs_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~utlCsN));

  assert_cs_outlasts_rd_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(utlRdN) |-> (utlCsN != CS_IDLE));

  assert_wr_after_ale_R5: assert property (@(posedge clk) disable iff (!rstN)
    !utlWrN |-> !utlAle && utlAdOe && (utlCsN != CS_IDLE));

  assert_wr_data_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(utlWrN) |-> utlAdOe && (utlCsN != CS_IDLE));

  assert_rd_released_R6: assert property (@(posedge clk) disable iff (!rstN)
    !utlRdN |-> !utlAdOe && !utlAle && utlWrN);

  assert_done_at_cs_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (utlCsN == CS_IDLE) && $past(utlCsN != CS_IDLE));

  assert_idle_at_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy && !utlAdOe);

endmodule

bind util_bus_master ubm_checker #(.NUM_CS(NUM_CS)) u_checker (
  .clk    (clk),
  .rstN   (rstN),
  .busy   (busy),
  .done   (done),
  .utlAle (utlAle),
  .utlCsN (utlCsN),
  .utlRdN (utlRdN),
  .utlWrN (utlWrN),
  .utlAdOe(utlAdOe)
);

// File: tb/util_bus_master_tb.sv
module util_bus_master_tb;

  localparam int ALE_CYC = 2;
  localparam int AHOLD   = 1;
  localparam int STB     = 15;
  localparam int DHOLD   = 1;
  localparam int CS_LEN  = ALE_CYC + AHOLD + STB + DHOLD;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0, reqWrite = 1'b0;
  logic [0:0] reqSel = '0;
  logic [7:0] reqAddr = '0, reqWdata = '0;
  logic       busy, done;
  logic [7:0] rdData;
  logic       utlAle, utlRdN, utlWrN, utlAdOe;
  logic [1:0] utlCsN;
  logic [7:0] utlAdOut, utlAdIn;
  logic       phyResetCtl = 1'b1, phyReset, phyIrq = 1'b0, irqClear = 1'b0, irqStatus;
  logic [7:0] earlyVal = 8'h00, lateVal = 8'h00;

  // Peripheral model: one byte while the read strobe is low, another after it.
  assign utlAdIn = !utlRdN ? earlyVal : lateVal;

  always #2.5 clk = ~clk;

  util_bus_master u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSel(reqSel), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .busy(busy), .done(done), .rdData(rdData),
    .utlAle(utlAle), .utlCsN(utlCsN), .utlRdN(utlRdN), .utlWrN(utlWrN),
    .utlAdOut(utlAdOut), .utlAdOe(utlAdOe), .utlAdIn(utlAdIn),
    .phyResetCtl(phyResetCtl), .phyReset(phyReset),
    .phyIrq(phyIrq), .irqClear(irqClear), .irqStatus(irqStatus)
  );

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  // Measurements of one transfer
  int         mAle, mWrLow, mRdLow, mCsLow, mAleRises, mExtraAle;
  logic [1:0] mCsSeen;
  logic [7:0] mAddrHold, mDataHold, mRd;
  bit         mAddrHoldOe, mDataHoldOe, mOeInRead, mBusyDrop, mGotDone, mBusyAtDone, mOeAfter;

  task automatic runXfer(input bit wr, input bit sel, input logic [7:0] a,
                         input logic [7:0] d, input int pokeAt);
    bit prevAle, prevWr, seenRd;
    mAle = 0; mWrLow = 0; mRdLow = 0; mCsLow = 0; mAleRises = 0; mExtraAle = 0;
    mCsSeen = '0; mAddrHold = '0; mDataHold = '0; mRd = '0;
    mAddrHoldOe = 0; mDataHoldOe = 0; mOeInRead = 0; mBusyDrop = 0;
    mGotDone = 0; mBusyAtDone = 1; mOeAfter = 1;
    prevAle = 0; prevWr = 1; seenRd = 0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqSel = sel; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (i == pokeAt) begin
        reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 8'hEE;
      end else if (i == pokeAt + 1) begin
        reqValid = 1'b0;
      end
      if (utlAle) mAle++;
      if (utlAle && !prevAle) mAleRises++;
      if (!utlAle && prevAle) begin mAddrHold = utlAdOut; mAddrHoldOe = utlAdOe; end
      if (!utlWrN) mWrLow++;
      if (utlWrN && !prevWr) begin mDataHold = utlAdOut; mDataHoldOe = utlAdOe; end
      if (!utlRdN) begin mRdLow++; seenRd = 1; end
      if (seenRd && utlAdOe) mOeInRead = 1;
      if (utlCsN != 2'b11) mCsLow++;
      mCsSeen |= ~utlCsN;
      if (done) begin
        mGotDone = 1; mRd = rdData; mBusyAtDone = busy;
        break;
      end
      if (!busy) mBusyDrop = 1;
      prevAle = utlAle; prevWr = utlWrN;
      @(negedge clk);
    end
    reqValid = 1'b0;
    @(negedge clk);
    mOeAfter = utlAdOe;
    for (int k = 0; k < 4; k++) begin
      if (utlAle) mExtraAle++;
      @(negedge clk);
    end
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(utlCsN == 2'b11 && utlRdN && utlWrN && !utlAle && !utlAdOe, "R1 bus idle in reset",
          {utlCsN, utlRdN, utlWrN, utlAle, utlAdOe}, 6'b111100);
    check(phyReset == 1'b1, "R10 phy reset during reset", phyReset, 1);
    phyResetCtl = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && utlCsN == 2'b11, "R1 idle after reset", {busy, done, utlCsN}, 4'b0011);
  endtask

  task automatic testWrite(input bit sel, input logic [7:0] a, input logic [7:0] d);
    runXfer(1'b1, sel, a, d, -1);
    check(mGotDone, "R8 write done seen", mGotDone, 1);
    check(mAle == ALE_CYC && mAleRises == 1, "R3 latch pulse width", mAle, ALE_CYC);
    check(mAddrHold == a && mAddrHoldOe, "R3 address held after latch", mAddrHold, a);
    check(mCsSeen == (sel ? 2'b10 : 2'b01), "R4 chip select decode", mCsSeen, sel ? 2 : 1);
    check(mCsLow == CS_LEN, "R4 chip select length", mCsLow, CS_LEN);
    check(mWrLow == STB && mRdLow == 0, "R5 write strobe width", mWrLow, STB);
    check(mDataHold == d && mDataHoldOe, "R5 write data hold", mDataHold, d);
    check(!mBusyDrop && !mBusyAtDone, "R2 busy span", {mBusyDrop, mBusyAtDone}, 0);
  endtask

  task automatic testRead(input bit sel, input logic [7:0] a, input logic [7:0] early, input logic [7:0] late);
    earlyVal = early; lateVal = late;
    runXfer(1'b0, sel, a, 8'h00, -1);
    check(mGotDone, "R8 read done seen", mGotDone, 1);
    check(mCsSeen == (sel ? 2'b10 : 2'b01), "R4 read chip select decode", mCsSeen, sel ? 2 : 1);
    check(mAddrHold == a && mAddrHoldOe, "R3 read address held", mAddrHold, a);
    check(mRdLow == STB && mWrLow == 0, "R6 read strobe width", mRdLow, STB);
    check(!mOeInRead && !mOeAfter, "R6 lines released in read", {mOeInRead, mOeAfter}, 0);
    check(mRd == late, "R7 data sampled at chip select rise", mRd, late);
  endtask

  task automatic testBusyIgnore();
    runXfer(1'b1, 1'b0, 8'h33, 8'h44, 4);
    check(mAleRises == 1 && mExtraAle == 0, "R2 request while busy ignored",
          mAleRises + mExtraAle, 1);
    check(!busy, "R2 idle after ignored request", busy, 0);
  endtask

  task automatic testIrq();
    @(negedge clk);
    check(!irqStatus, "R9 status clear initially", irqStatus, 0);
    phyIrq = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!irqStatus, "R9 not visible after two edges", irqStatus, 0);
    @(negedge clk);
    check(irqStatus, "R9 visible after three edges", irqStatus, 1);
    irqClear = 1'b1;
    @(negedge clk);
    irqClear = 1'b0;
    check(irqStatus, "R9 clear ignored while input high", irqStatus, 1);
    phyIrq = 1'b0;
    repeat (3) @(negedge clk);
    check(irqStatus, "R9 sticky after input low", irqStatus, 1);
    irqClear = 1'b1;
    @(negedge clk);
    irqClear = 1'b0;
    check(!irqStatus, "R9 cleared", irqStatus, 0);
  endtask

  task automatic testPhyReset();
    @(negedge clk);
    check(!phyReset, "R10 follows control low", phyReset, 0);
    phyResetCtl = 1'b1;
    @(negedge clk);
    check(phyReset, "R10 follows control high", phyReset, 1);
    phyResetCtl = 1'b0;
    @(negedge clk);
    check(!phyReset, "R10 follows control back low", phyReset, 0);
  endtask

  initial begin
    testReset();
    testWrite(1'b0, 8'h5A, 8'hC3);
    testWrite(1'b1, 8'hA1, 8'h0F);
    testRead(1'b0, 8'h12, 8'h99, 8'h6B);
    testRead(1'b1, 8'hF0, 8'h11, 8'hD4);
    testBusyIgnore();
    testIrq();
    testPhyReset();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule